// File: doc/BRIEF.md
# Dual-Synthesizer Powerdown Controller

This block sets the power mode of a part that carries two frequency synthesizer channels. Each channel has two latched control bits, a tristate bit and a powerdown bit. Together they pick one of four modes: normal operation, active with the charge pump output floated, powerdown after the charge-pump pulse in flight has finished, or immediate powerdown. The block turns these bits into the enables for each channel's prescaler, phase detector and charge pump. It also drives high-impedance controls for the charge-pump and RF input pins and a hold signal that keeps both dividers of a channel at their load point.

One oscillator buffer serves both channels. It is switched off only when both channels are down, and in that state the reference input is flagged as pulled high. When a channel wakes up, its blocks and the oscillator buffer come on at once. Its dividers stay held for a settle time of `SETTLE_CYC` reference clock cycles and are then released together. The control bits may change in any mode, powerdown included, and each change is acted on at the next clock edge.

Top module: `dsyn_pwr_ctrl`

## Requirements
- R1: With tristate=0 and powerdown=0 held, an active channel has prescaler, phase detector and charge pump enabled, cp_hiz=0, rfin_hiz=0 and div_hold=0.
- R2: With tristate=1 and powerdown=0, the channel stays enabled with div_hold=0, but cp_hiz=1.
- R3: tristate=0 with powerdown=1 on an active channel is a synchronous request. The channel stays enabled until a pulse_done strobe is sampled in a cycle after the one in which the request was first sampled. It is powered down from the clock edge that samples that strobe. A strobe sampled in the same cycle as the new request does not count.
- R4: tristate=1 with powerdown=1 powers the channel down at the next clock edge, whether it was active or waiting for a pulse.
- R5: A powered-down channel has all three enables at 0 and cp_hiz=1, rfin_hiz=1 and div_hold=1.
- R6: osc_en is 0 and ref_pullup is 1 exactly when both channels are powered down. Otherwise osc_en is 1 and ref_pullup is 0.
- R7: Clearing powerdown on a down channel enables its blocks, and osc_en, at the next edge. div_hold stays 1 (and cp_hiz 1) for exactly SETTLE_CYC cycles and then drops to 0.
- R8: Clearing powerdown while a synchronous request is pending cancels it. The channel returns to active, or to tristate if tristate=1, and later pulse_done strobes have no effect.
- R9: Setting powerdown during the settle time powers the channel down at the next edge, whatever the tristate bit is.
- R10: During and right after reset both channels are powered down, with osc_en=0 and ref_pullup=1.
- R11: The two channels are independent: one channel's bits and strobe do not change the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tri_bit | input | NCH | Latched tristate bit per channel |
| pwdn_bit | input | NCH | Latched powerdown bit per channel |
| pulse_done | input | NCH | Strobe: a charge-pump pulse event has completed |
| presc_en | output | NCH | Prescaler enable |
| phdet_en | output | NCH | Phase detector enable |
| cp_en | output | NCH | Charge pump enable |
| cp_hiz | output | NCH | Charge-pump output pin high impedance |
| rfin_hiz | output | NCH | RF input pins high impedance |
| div_hold | output | NCH | Hold reference and feedback dividers at load point |
| osc_en | output | 1 | Shared oscillator buffer enable |
| ref_pullup | output | 1 | Reference input pulled high (oscillator off) |

## Verification
Several properties are checked on every cycle. A powered-down channel has a consistent set of outputs. The oscillator enable matches the OR of the channel enables. An immediate-down request always takes effect at the next edge. Without a strobe, a synchronous request never drops an active channel. An abort during settle powers the channel down. A counter in the checker confirms that every divider release comes after exactly SETTLE_CYC held cycles. Some behaviour only the bench scenarios can show: a strobe in the request cycle is ignored, a cancelled request stays cancelled when later strobes arrive, the oscillator turns off only after the last channel goes down, and the two channels stay independent. These are compared against a behavioural model on every clock.

// File: rtl/dsyn_pwr_pkg.sv
package dsyn_pwr_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE     = 3'd0,
        ST_TRISTATE   = 3'd1,
        ST_WAIT_PULSE = 3'd2,
        ST_DOWN       = 3'd3,
        ST_SETTLE     = 3'd4
    } chan_state_e;

    typedef struct packed {
        logic presc_en;
        logic phdet_en;
        logic cp_en;
        logic cp_hiz;
        logic rfin_hiz;
        logic div_hold;
    } chan_out_t;

    // Moore decode of one channel's controls from its state
    function automatic chan_out_t decode_outputs(chan_state_e st);
        chan_out_t o;
        o = '0;
        case (st)
            ST_ACTIVE, ST_WAIT_PULSE: begin
                o.presc_en = 1'b1;
                o.phdet_en = 1'b1;
                o.cp_en    = 1'b1;
            end
            ST_TRISTATE: begin
                o.presc_en = 1'b1;
                o.phdet_en = 1'b1;
                o.cp_en    = 1'b1;
                o.cp_hiz   = 1'b1;
            end
            ST_SETTLE: begin
                o.presc_en = 1'b1;
                o.phdet_en = 1'b1;
                o.cp_en    = 1'b1;
                o.cp_hiz   = 1'b1;
                o.div_hold = 1'b1;
            end
            default: begin
                o.cp_hiz   = 1'b1;
                o.rfin_hiz = 1'b1;
                o.div_hold = 1'b1;
            end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dsyn_pwr_chan.sv
module dsyn_pwr_chan
    import dsyn_pwr_pkg::*;
#(
    parameter int SETTLE_CYC = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tri_bit,
    input  logic      pwdn_bit,
    input  logic      pulse_done,
    output chan_out_t ctl,
    output logic      live
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        chan_state_e      st;
        logic [CNT_W-1:0] cnt;
    } chan_regs_t;

    chan_regs_t r_d, r_q;

    // Mode that the current bits select when no powerdown is pending
    function automatic chan_state_e run_mode(logic t);
        return t ? ST_TRISTATE : ST_ACTIVE;
    endfunction

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_ACTIVE, ST_TRISTATE: begin
                if (pwdn_bit && tri_bit) begin
                    r_d.st = ST_DOWN;
                end else if (pwdn_bit) begin
                    r_d.st = ST_WAIT_PULSE;
                end else begin
                    r_d.st = run_mode(tri_bit);
                end
            end
            ST_WAIT_PULSE: begin
                if (!pwdn_bit) begin
                    r_d.st = run_mode(tri_bit);
                end else if (tri_bit || pulse_done) begin
                    r_d.st = ST_DOWN;
                end
            end
            ST_DOWN: begin
                if (!pwdn_bit) begin
                    r_d.st  = ST_SETTLE;
                    r_d.cnt = CNT_LOAD;
                end
            end
            ST_SETTLE: begin
                if (pwdn_bit) begin
                    r_d.st  = ST_DOWN;
                    r_d.cnt = '0;
                end else if (r_q.cnt == '0) begin
                    r_d.st = run_mode(tri_bit);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d.st  = ST_DOWN;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_DOWN;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl  = decode_outputs(r_q.st);
    assign live = (r_q.st != ST_DOWN);

endmodule

// File: rtl/dsyn_pwr_osc.sv
module dsyn_pwr_osc #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] live,
    output logic           osc_en,
    output logic           ref_pullup
);

    logic [NCH:0] any_live;

    assign any_live[0] = 1'b0;

    for (genvar g = 0; g < NCH; g++) begin : g_or
        assign any_live[g+1] = any_live[g] | live[g];
    end

    assign osc_en     = any_live[NCH];
    assign ref_pullup = ~any_live[NCH];

endmodule

// File: rtl/dsyn_pwr_ctrl.sv
module dsyn_pwr_ctrl
    import dsyn_pwr_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int SETTLE_CYC = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tri_bit,
    input  logic [NCH-1:0] pwdn_bit,
    input  logic [NCH-1:0] pulse_done,
    output logic [NCH-1:0] presc_en,
    output logic [NCH-1:0] phdet_en,
    output logic [NCH-1:0] cp_en,
    output logic [NCH-1:0] cp_hiz,
    output logic [NCH-1:0] rfin_hiz,
    output logic [NCH-1:0] div_hold,
    output logic           osc_en,
    output logic           ref_pullup
);

    logic [NCH-1:0] chan_live;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        chan_out_t ctl;

        dsyn_pwr_chan #(
            .SETTLE_CYC (SETTLE_CYC)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tri_bit    (tri_bit[g]),
            .pwdn_bit   (pwdn_bit[g]),
            .pulse_done (pulse_done[g]),
            .ctl        (ctl),
            .live       (chan_live[g])
        );

        assign presc_en[g] = ctl.presc_en;
        assign phdet_en[g] = ctl.phdet_en;
        assign cp_en[g]    = ctl.cp_en;
        assign cp_hiz[g]   = ctl.cp_hiz;
        assign rfin_hiz[g] = ctl.rfin_hiz;
        assign div_hold[g] = ctl.div_hold;
    end

    dsyn_pwr_osc #(
        .NCH (NCH)
    ) u_osc (
        .live       (chan_live),
        .osc_en     (osc_en),
        .ref_pullup (ref_pullup)
    );

endmodule

// File: rtl/dsyn_pwr_chk.sv
module dsyn_pwr_chk #(
    parameter int NCH        = 2,
    parameter int SETTLE_CYC = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] tri_bit,
    input logic [NCH-1:0] pwdn_bit,
    input logic [NCH-1:0] pulse_done,
    input logic [NCH-1:0] presc_en,
    input logic [NCH-1:0] phdet_en,
    input logic [NCH-1:0] cp_en,
    input logic [NCH-1:0] cp_hiz,
    input logic [NCH-1:0] rfin_hiz,
    input logic [NCH-1:0] div_hold,
    input logic           osc_en,
    input logic           ref_pullup
);

    p_osc_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en == (|presc_en)) && (ref_pullup == !osc_en));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        int unsigned held_run;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_run <= 0;
            end else if (presc_en[g] && div_hold[g]) begin
                held_run <= held_run + 1;
            end else begin
                held_run <= 0;
            end
        end

        p_down_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !presc_en[g] |-> (!phdet_en[g] && !cp_en[g] && cp_hiz[g]
                              && rfin_hiz[g] && div_hold[g]));

        p_async_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tri_bit[g] && pwdn_bit[g]) |=> !presc_en[g]);

        p_sync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (presc_en[g] && !div_hold[g] && !tri_bit[g] && !pulse_done[g])
            |=> presc_en[g]);

        p_cancel_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (presc_en[g] && !div_hold[g] && !pwdn_bit[g]) |=> presc_en[g]);

        p_settle_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (presc_en[g] && div_hold[g] && pwdn_bit[g]) |=> !presc_en[g]);

        p_settle_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(div_hold[g]) && presc_en[g]) |-> (held_run == SETTLE_CYC));
    end

endmodule

bind dsyn_pwr_ctrl dsyn_pwr_chk #(
    .NCH        (NCH),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tri_bit    (tri_bit),
    .pwdn_bit   (pwdn_bit),
    .pulse_done (pulse_done),
    .presc_en   (presc_en),
    .phdet_en   (phdet_en),
    .cp_en      (cp_en),
    .cp_hiz     (cp_hiz),
    .rfin_hiz   (rfin_hiz),
    .div_hold   (div_hold),
    .osc_en     (osc_en),
    .ref_pullup (ref_pullup)
);

// File: tb/dsyn_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module dsyn_pwr_ctrl_tb;

    localparam int NCH    = 2;
    localparam int SETTLE = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] tri_bit = '0;
    logic [NCH-1:0] pwdn_bit = '0;
    logic [NCH-1:0] pulse_done = '0;
    logic [NCH-1:0] presc_en, phdet_en, cp_en, cp_hiz, rfin_hiz, div_hold;
    logic           osc_en, ref_pullup;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // behavioural model state per channel
    bit m_down [NCH];
    bit m_pend [NCH];
    bit m_trim [NCH];
    int m_left [NCH];

    always #2.5 clk = ~clk;

    dsyn_pwr_ctrl #(
        .NCH        (NCH),
        .SETTLE_CYC (SETTLE)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tri_bit    (tri_bit),
        .pwdn_bit   (pwdn_bit),
        .pulse_done (pulse_done),
        .presc_en   (presc_en),
        .phdet_en   (phdet_en),
        .cp_en      (cp_en),
        .cp_hiz     (cp_hiz),
        .rfin_hiz   (rfin_hiz),
        .div_hold   (div_hold),
        .osc_en     (osc_en),
        .ref_pullup (ref_pullup)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // model update at each edge
    always @(posedge clk) begin
        cycles++;
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_down[c] = 1'b1; m_pend[c] = 1'b0; m_trim[c] = 1'b0; m_left[c] = 0;
            end else if (m_down[c]) begin
                if (!pwdn_bit[c]) begin
                    m_down[c] = 1'b0; m_left[c] = SETTLE;
                end
            end else if (m_left[c] > 0) begin
                if (pwdn_bit[c]) begin
                    m_down[c] = 1'b1; m_left[c] = 0;
                end else begin
                    m_left[c] = m_left[c] - 1;
                    if (m_left[c] == 0) m_trim[c] = tri_bit[c];
                end
            end else if (m_pend[c]) begin
                if (!pwdn_bit[c]) begin
                    m_pend[c] = 1'b0; m_trim[c] = tri_bit[c];
                end else if (tri_bit[c] || pulse_done[c]) begin
                    m_pend[c] = 1'b0; m_down[c] = 1'b1;
                end
            end else begin
                if (pwdn_bit[c] && tri_bit[c]) begin
                    m_down[c] = 1'b1;
                end else if (pwdn_bit[c]) begin
                    m_pend[c] = 1'b1; m_trim[c] = 1'b0;
                end else begin
                    m_trim[c] = tri_bit[c];
                end
            end
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int live;
            live = 0;
            for (int c = 0; c < NCH; c++) begin
                string req;
                bit exp_en, exp_hold, exp_cph;
                exp_en   = !m_down[c];
                exp_hold = m_down[c] || (m_left[c] > 0);
                exp_cph  = exp_hold || (!m_pend[c] && m_trim[c]);
                if (m_down[c])          req = "R5";
                else if (m_left[c] > 0) req = "R7";
                else if (m_trim[c])     req = "R2";
                else                    req = "R1";
                if (exp_en) live++;
                check(req, $sformatf("ch%0d presc_en", c), int'(presc_en[c]), int'(exp_en));
                check(req, $sformatf("ch%0d phdet_en", c), int'(phdet_en[c]), int'(exp_en));
                check(req, $sformatf("ch%0d cp_en", c),    int'(cp_en[c]),    int'(exp_en));
                check(req, $sformatf("ch%0d div_hold", c), int'(div_hold[c]), int'(exp_hold));
                check(req, $sformatf("ch%0d cp_hiz", c),   int'(cp_hiz[c]),   int'(exp_cph));
                check(req, $sformatf("ch%0d rfin_hiz", c), int'(rfin_hiz[c]), int'(m_down[c]));
            end
            check("R6", "osc_en",     int'(osc_en),     int'(live > 0));
            check("R6", "ref_pullup", int'(ref_pullup), int'(live == 0));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=%0d expected<%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        step(3);
        check("R10", "presc_en in reset", int'(presc_en), 0);
        check("R10", "osc_en in reset", int'(osc_en), 0);
        check("R10", "ref_pullup in reset", int'(ref_pullup), 1);
        rst_n = 1'b1;
        pwdn_bit = '1;
        step(2);
        check("R10", "presc_en after reset", int'(presc_en), 0);

        // R7: wake both channels, hold for SETTLE cycles
        pwdn_bit = '0;
        step(1);
        check("R7", "enables on wake", int'(presc_en), 3);
        check("R7", "osc_en on wake", int'(osc_en), 1);
        check("R7", "hold on wake", int'(div_hold), 3);
        step(SETTLE - 1);
        check("R7", "hold in last settle cycle", int'(div_hold), 3);
        step(1);
        check("R7", "hold released", int'(div_hold), 0);
        check("R1", "cp_hiz normal", int'(cp_hiz), 0);

        // R2: tristate on ch0
        tri_bit[0] = 1'b1;
        step(2);
        check("R2", "ch0 cp_hiz", int'(cp_hiz[0]), 1);
        check("R2", "ch0 presc_en", int'(presc_en[0]), 1);
        tri_bit[0] = 1'b0;

        // R3: sync request, strobe in request cycle ignored
        pwdn_bit[0] = 1'b1;
        pulse_done[0] = 1'b1;
        step(1);
        pulse_done[0] = 1'b0;
        step(4);
        check("R3", "ch0 waits for pulse", int'(presc_en[0]), 1);
        pulse_done[0] = 1'b1;
        step(1);
        pulse_done[0] = 1'b0;
        check("R3", "ch0 down after pulse", int'(presc_en[0]), 0);
        check("R11", "ch1 unaffected", int'(presc_en[1]), 1);

        // R4, R6: async down on ch1, both down
        tri_bit[1] = 1'b1;
        pwdn_bit[1] = 1'b1;
        step(1);
        check("R4", "ch1 immediate down", int'(presc_en[1]), 0);
        check("R6", "osc off both down", int'(osc_en), 0);
        check("R6", "pullup both down", int'(ref_pullup), 1);

        // R7: wake ch0, osc back at once
        pwdn_bit[0] = 1'b0;
        step(1);
        check("R7", "osc on with one wake", int'(osc_en), 1);
        step(SETTLE + 1);
        check("R7", "ch0 released", int'(div_hold[0]), 0);

        // R8: cancel pending request
        pwdn_bit[0] = 1'b1;
        step(3);
        pwdn_bit[0] = 1'b0;
        step(2);
        pulse_done[0] = 1'b1;
        step(1);
        pulse_done[0] = 1'b0;
        step(1);
        check("R8", "ch0 still active after cancel", int'(presc_en[0]), 1);

        // R9: abort settle on ch1 with tristate=0
        tri_bit[1] = 1'b0;
        pwdn_bit[1] = 1'b0;
        step(3);
        pwdn_bit[1] = 1'b1;
        step(1);
        check("R9", "ch1 down on settle abort", int'(presc_en[1]), 0);

        // R4: async from pending sync request
        pwdn_bit[0] = 1'b1;
        step(2);
        tri_bit[0] = 1'b1;
        step(1);
        check("R4", "ch0 down from wait", int'(presc_en[0]), 0);
        check("R6", "osc off at end", int'(osc_en), 0);

        step(3);
        finish_run();
    end

endmodule